// File: doc/BRIEF.md
# System Reset Merger with Cause Record

This block produces the single active-high system reset for a chip. Three kinds of cause feed it: a power-on qualifier, an active-low external reset pin, and three undervoltage flags, one for each monitored supply rail. The power-on qualifier delivers a reset pulse and a supply-good level. The pin and the rail flags are asynchronous levels, so each passes through a two-flop synchronizer. Each is then filtered against its own minimum dwell, counted in clock cycles, before it may act. All analog sensing happens outside the block, and every input arrives as a digital level.

The reset output is registered. It stays high while any qualified cause is present and falls only when none is. A three-bit sticky record shows which kinds of cause have asserted reset since software last cleared it. A power-on cause wipes the record down to its power-on bit alone. The power-on pulse clears the synchronizers, the filters and the output flop asynchronously. The cause record is written only on clock edges.

Top module: `rst_source_merge`

## Requirements
- R1: While `por_pulse_i` is high, `sys_rst_o` is high without waiting for a clock edge. The pulse also clears the pin and rail filters, so a pin that is still low when the pulse ends must qualify again for the full assert dwell before it holds reset.
- R2: The pin asserts reset only after its synchronized value has been low on `EXT_ASSERT_CYC` consecutive edges. `sys_rst_o` rises on the (`EXT_ASSERT_CYC`+3)th rising edge after the first edge that samples the pin low. Any shorter low pulse has no effect.
- R3: Once the pin holds reset, it releases only after its synchronized value has been high on `EXT_RELEASE_CYC` consecutive edges. The pin's effect on `sys_rst_o` ends on the (`EXT_RELEASE_CYC`+3)th edge. Any shorter high pulse has no effect.
- R4: Rail flag k (bit 0 is the 1.5 V rail, bit 1 is the 1.2 V rail, bit 2 is the 0.9 V rail) asserts reset only after it has been high for its own dwell `LVD_CYC_k`. `sys_rst_o` then rises on the (`LVD_CYC_k`+3)th edge. A shorter high pulse has no effect.
- R5: A qualified rail flag stops holding reset at once when the flag drops. When nothing else holds reset, `sys_rst_o` falls on the 4th edge after the flag goes low.
- R6: `sys_rst_o` is the registered OR of three conditions: the power-on cause (pulse high or supply-good low), the qualified pin and any qualified rail. It goes low only when all three are inactive.
- R7: `cause_o` has bit 0 for power-on, bit 1 for the external pin and bit 2 for any rail. A bit is set on the edge after its cause qualifies, and it stays set until it is cleared.
- R8: While the power-on cause is active, `cause_o` reads 3'b001 one edge later, whatever the other causes are doing.
- R9: A high `cause_clr_i` on an edge clears `cause_o`. A pin or rail cause that is still qualified on that same edge sets its bit again.
- R10: After a power-on pulse that spans at least one clock edge, `sys_rst_o` is 1 and `cause_o` is 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_pulse_i | input | 1 | Power-on reset pulse, active high, acts asynchronously |
| pwr_good_i | input | 1 | Supply-good level from the power-on qualifier |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| lvd_flag_i | input | 3 | Undervoltage flags: [0] 1.5 V, [1] 1.2 V, [2] 0.9 V rail |
| cause_clr_i | input | 1 | Clear strobe for the cause record |
| sys_rst_o | output | 1 | Merged system reset, active high |
| cause_o | output | 3 | Sticky cause record: [0] power-on, [1] pin, [2] rail |

## Verification
A dwell counter that is off by one moves the edge of `sys_rst_o` by one cycle when a cause qualifies or releases. The bench measures that edge exactly, and its per-edge model flags the mismatch in the cycle where it happens. A filter state that is stuck, or that was not cleared by the power-on pulse, either holds `sys_rst_o` high after every cause has gone or leaves it low during a long pin assertion. A cause record that is corrupt, or that is not overridden by power-on, shows on `cause_o` one edge after the condition that should have set or cleared it.

// File: rtl/rstm_pkg.sv
package rstm_pkg;

    localparam int RAIL_COUNT = 3;

    typedef struct packed {
        logic lvd;
        logic ext;
        logic pwr;
    } cause_t;

    localparam cause_t CAUSE_NONE = '{lvd: 1'b0, ext: 1'b0, pwr: 1'b0};
    localparam cause_t CAUSE_PWR_ONLY = '{lvd: 1'b0, ext: 1'b0, pwr: 1'b1};

    function automatic int dwell_bits(input int cycles);
        return (cycles < 2) ? 1 : $clog2(cycles + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rstm_sync.sv
module rstm_sync #(
    parameter int   WIDTH   = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            stage1_q <= {WIDTH{RST_VAL}};
            stage2_q <= {WIDTH{RST_VAL}};
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/rstm_dwell.sv
module rstm_dwell
    import rstm_pkg::*;
#(
    parameter int SET_CYC = 4,
    parameter int CLR_CYC = 1
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic level_i,
    output logic state_o
);

    localparam int CW = dwell_bits(max2(SET_CYC, CLR_CYC));
    localparam logic [CW-1:0] SET_LAST = CW'(SET_CYC - 1);
    localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CYC - 1);

    logic [CW-1:0] run_q;
    logic          state_q;
    logic [CW-1:0] limit;

    assign limit = state_q ? CLR_LAST : SET_LAST;

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            run_q   <= '0;
            state_q <= 1'b0;
        end else if (level_i != state_q) begin
            if (run_q == limit) begin
                state_q <= level_i;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rstm_cause_log.sv
module rstm_cause_log
    import rstm_pkg::*;
(
    input  logic   clk_i,
    input  logic   pwr_act_i,
    input  logic   ext_act_i,
    input  logic   lvd_act_i,
    input  logic   clr_i,
    output cause_t cause_o
);

    cause_t cause_q;
    cause_t cause_d;

    always_comb begin
        if (pwr_act_i) begin
            cause_d = CAUSE_PWR_ONLY;
        end else begin
            cause_d     = clr_i ? CAUSE_NONE : cause_q;
            cause_d.ext = cause_d.ext | ext_act_i;
            cause_d.lvd = cause_d.lvd | lvd_act_i;
        end
    end

    always_ff @(posedge clk_i) begin
        cause_q <= cause_d;
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/rst_source_merge.sv
module rst_source_merge
    import rstm_pkg::*;
#(
    parameter int EXT_ASSERT_CYC  = 250,
    parameter int EXT_RELEASE_CYC = 250,
    parameter int LVD_CYC_0       = 4000,
    parameter int LVD_CYC_1       = 2000,
    parameter int LVD_CYC_2       = 2000
) (
    input  logic                  clk_i,
    input  logic                  por_pulse_i,
    input  logic                  pwr_good_i,
    input  logic                  ext_rst_n_i,
    input  logic [RAIL_COUNT-1:0] lvd_flag_i,
    input  logic                  cause_clr_i,
    output logic                  sys_rst_o,
    output logic [2:0]            cause_o
);

    logic                  ext_pin_s;
    logic                  ext_level;
    logic                  ext_state;
    logic [RAIL_COUNT-1:0] lvd_sync;
    logic [RAIL_COUNT-1:0] lvd_state;
    logic                  pwr_act;
    logic                  lvd_any;
    logic                  rst_q;
    cause_t                cause;

    assign pwr_act = por_pulse_i | ~pwr_good_i;

    rstm_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_ext_sync (
        .clk_i  (clk_i),
        .arst_i (por_pulse_i),
        .d_i    (ext_rst_n_i),
        .q_o    (ext_pin_s)
    );

    assign ext_level = ~ext_pin_s;

    rstm_dwell #(.SET_CYC(EXT_ASSERT_CYC), .CLR_CYC(EXT_RELEASE_CYC)) u_ext_dwell (
        .clk_i   (clk_i),
        .arst_i  (por_pulse_i),
        .level_i (ext_level),
        .state_o (ext_state)
    );

    rstm_sync #(.WIDTH(RAIL_COUNT), .RST_VAL(1'b0)) u_lvd_sync (
        .clk_i  (clk_i),
        .arst_i (por_pulse_i),
        .d_i    (lvd_flag_i),
        .q_o    (lvd_sync)
    );

    for (genvar g = 0; g < RAIL_COUNT; g++) begin : g_rail
        localparam int RAIL_CYC = (g == 0) ? LVD_CYC_0 :
                                  (g == 1) ? LVD_CYC_1 : LVD_CYC_2;
        rstm_dwell #(.SET_CYC(RAIL_CYC), .CLR_CYC(1)) u_rail_dwell (
            .clk_i   (clk_i),
            .arst_i  (por_pulse_i),
            .level_i (lvd_sync[g]),
            .state_o (lvd_state[g])
        );
    end

    assign lvd_any = |lvd_state;

    always_ff @(posedge clk_i or posedge por_pulse_i) begin
        if (por_pulse_i) begin
            rst_q <= 1'b1;
        end else begin
            rst_q <= pwr_act | ext_state | lvd_any;
        end
    end

    rstm_cause_log u_cause (
        .clk_i     (clk_i),
        .pwr_act_i (pwr_act),
        .ext_act_i (ext_state),
        .lvd_act_i (lvd_any),
        .clr_i     (cause_clr_i),
        .cause_o   (cause)
    );

    assign sys_rst_o = rst_q;
    assign cause_o   = cause;

endmodule

// File: rtl/rstm_checker.sv
module rstm_checker (
    input logic       clk_i,
    input logic       por_pulse_i,
    input logic       pwr_good_i,
    input logic       cause_clr_i,
    input logic       sys_rst_o,
    input logic [2:0] cause_o,
    input logic       ext_level,
    input logic       ext_state,
    input logic [2:0] lvd_sync,
    input logic [2:0] lvd_state
);

    always @(negedge clk_i) begin
        if (por_pulse_i) begin
            a_r1_por_forces_rst: assert (sys_rst_o === 1'b1);
        end
    end

    a_r2_pin_needs_low: assert property (@(posedge clk_i) disable iff (por_pulse_i)
        $rose(ext_state) |-> $past(ext_level));

    a_r4_rail_needs_flag: assert property (@(posedge clk_i) disable iff (por_pulse_i)
        ((lvd_state & ~$past(lvd_state)) & ~$past(lvd_sync)) == 3'b000);

    a_r6_release_all_quiet: assert property (@(posedge clk_i) disable iff (por_pulse_i)
        $fell(sys_rst_o) |-> $past(pwr_good_i && !ext_state && (lvd_state == 3'b000)));

    a_r7_bits_sticky: assert property (@(posedge clk_i) disable iff (por_pulse_i)
        (!cause_clr_i && pwr_good_i) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

    a_r8_power_overrides: assert property (@(posedge clk_i) disable iff (por_pulse_i)
        !pwr_good_i |=> (cause_o == 3'b001));

endmodule

bind rst_source_merge rstm_checker u_rstm_checker (
    .clk_i       (clk_i),
    .por_pulse_i (por_pulse_i),
    .pwr_good_i  (pwr_good_i),
    .cause_clr_i (cause_clr_i),
    .sys_rst_o   (sys_rst_o),
    .cause_o     (cause_o),
    .ext_level   (ext_level),
    .ext_state   (ext_state),
    .lvd_sync    (lvd_sync),
    .lvd_state   (lvd_state)
);

// File: tb/rst_source_merge_bench.sv
`timescale 1ns/1ps
module rst_source_merge_bench;

    localparam int EXT_A = 6;
    localparam int EXT_R = 9;
    localparam int L0    = 12;
    localparam int L1    = 5;
    localparam int L2    = 8;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       pwr_good = 1'b0;
    logic       ext_n = 1'b1;
    logic [2:0] lvd = 3'b000;
    logic       clr = 1'b0;
    logic       sys_rst;
    logic [2:0] cause;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    cmp_on   = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R10";

    always #2 clk = ~clk;

    rst_source_merge #(
        .EXT_ASSERT_CYC (EXT_A),
        .EXT_RELEASE_CYC(EXT_R),
        .LVD_CYC_0      (L0),
        .LVD_CYC_1      (L1),
        .LVD_CYC_2      (L2)
    ) u_rst_source_merge (
        .clk_i       (clk),
        .por_pulse_i (por),
        .pwr_good_i  (pwr_good),
        .ext_rst_n_i (ext_n),
        .lvd_flag_i  (lvd),
        .cause_clr_i (clr),
        .sys_rst_o   (sys_rst),
        .cause_o     (cause)
    );

    // behavioural reference, one step per rising edge
    bit         m_p1, m_p2, m_ext;
    int         m_ext_run;
    bit         m_l1 [3];
    bit         m_l2 [3];
    bit         m_lst [3];
    int         m_lrun [3];
    bit         m_rst;
    logic [2:0] m_cause = 3'bxxx;

    function automatic int rail_dwell(input int k);
        return (k == 0) ? L0 : (k == 1) ? L1 : L2;
    endfunction

    always @(posedge clk) begin
        bit pa;
        bit any_l;
        any_l = m_lst[0] | m_lst[1] | m_lst[2];
        pa    = por | ~pwr_good;
        if (pa) m_cause = 3'b001;
        else begin
            if (clr) m_cause = 3'b000;
            if (m_ext) m_cause[1] = 1'b1;
            if (any_l) m_cause[2] = 1'b1;
        end
        if (por) begin
            m_p1 = 1; m_p2 = 1; m_ext = 0; m_ext_run = 0; m_rst = 1;
            for (int k = 0; k < 3; k++) begin
                m_l1[k] = 0; m_l2[k] = 0; m_lst[k] = 0; m_lrun[k] = 0;
            end
        end else begin
            m_rst = pa | m_ext | any_l;
            if (bit'(!m_p2) != m_ext) begin
                if (m_ext_run == (m_ext ? EXT_R : EXT_A) - 1) begin
                    m_ext = !m_p2; m_ext_run = 0;
                end else m_ext_run++;
            end else m_ext_run = 0;
            for (int k = 0; k < 3; k++) begin
                if (m_l2[k] != m_lst[k]) begin
                    if (m_lrun[k] == (m_lst[k] ? 1 : rail_dwell(k)) - 1) begin
                        m_lst[k] = m_l2[k]; m_lrun[k] = 0;
                    end else m_lrun[k]++;
                end else m_lrun[k] = 0;
                m_l2[k] = m_l1[k];
                m_l1[k] = lvd[k];
            end
            m_p2 = m_p1;
            m_p1 = ext_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk({cur_req, " model sys_rst"}, int'(sys_rst), int'(m_rst));
            chk({cur_req, " model cause"}, int'(cause), int'(m_cause));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic edges_until(input logic target, output int k);
        k = 0;
        while (sys_rst !== target && k < 300) begin
            @(posedge clk); #1; k++;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int k;
        tick(4);
        cur_req = "R10";
        chk("R10 reset sys_rst", int'(sys_rst), 1);
        chk("R10 reset cause", int'(cause), 1);
        cmp_on = 1'b1;

        por = 0; pwr_good = 1;
        cur_req = "R6";
        tick(3);
        chk("R6 all quiet releases", int'(sys_rst), 0);
        chk("R7 power bit sticky", int'(cause), 1);

        cur_req = "R9";
        clr = 1; tick(1); clr = 0;
        chk("R9 clear strobe", int'(cause), 0);

        cur_req = "R2";
        ext_n = 0; tick(EXT_A - 1); ext_n = 1; tick(10);
        chk("R2 short low ignored", int'(sys_rst), 0);
        chk("R2 short low no cause", int'(cause), 0);
        ext_n = 0;
        edges_until(1'b1, k);
        chk("R2 assert latency", k, EXT_A + 3);
        cur_req = "R7";
        tick(1);
        chk("R7 pin cause bit", int'(cause), 2);

        cur_req = "R3";
        ext_n = 1; tick(EXT_R - 1); ext_n = 0; tick(10);
        chk("R3 short high ignored", int'(sys_rst), 1);
        ext_n = 1;
        edges_until(1'b0, k);
        chk("R3 release latency", k, EXT_R + 3);

        for (int r = 0; r < 3; r++) begin
            cur_req = "R4";
            lvd[r] = 1; tick(rail_dwell(r) - 1); lvd[r] = 0; tick(8);
            chk("R4 short rail pulse ignored", int'(sys_rst), 0);
            lvd[r] = 1;
            edges_until(1'b1, k);
            chk("R4 rail assert latency", k, rail_dwell(r) + 3);
            tick(1);
            chk("R7 rail cause bits", int'(cause), (r == 0) ? 6 : 4);
            cur_req = "R5";
            lvd[r] = 0;
            edges_until(1'b0, k);
            chk("R5 rail release latency", k, 4);
            clr = 1; tick(1); clr = 0;
        end

        cur_req = "R6";
        ext_n = 0; tick(EXT_A + 5);
        lvd[1] = 1; tick(L1 + 5); lvd[1] = 0; tick(8);
        chk("R6 pin still holds reset", int'(sys_rst), 1);

        cur_req = "R9";
        lvd[2] = 1; tick(L2 + 5);
        clr = 1; tick(1); clr = 0;
        chk("R9 active causes re-set", int'(cause), 6);
        lvd[2] = 0; ext_n = 1; tick(EXT_R + 8);
        chk("R6 released when quiet", int'(sys_rst), 0);

        cur_req = "R8";
        clr = 1; tick(1); clr = 0;
        ext_n = 0; tick(EXT_A + 5);
        chk("R8 pin cause before power loss", int'(cause), 2);
        pwr_good = 0; tick(1);
        chk("R8 power overrides", int'(cause), 1);
        tick(3);
        chk("R8 override persists", int'(cause), 1);
        chk("R6 power holds reset", int'(sys_rst), 1);

        cur_req = "R1";
        @(posedge clk); #1;
        por = 1; #0.5;
        chk("R1 pulse forces reset", int'(sys_rst), 1);
        tick(3);
        por = 0; pwr_good = 1;
        tick(1);
        chk("R1 filters cleared", int'(sys_rst), 0);
        tick(EXT_A + 1);
        chk("R1 pin not yet requalified", int'(sys_rst), 0);
        tick(1);
        chk("R1 pin requalified", int'(sys_rst), 1);
        ext_n = 1; tick(EXT_R + 8);
        chk("R3 final release", int'(sys_rst), 0);

        finish_run();
    end

endmodule